// File: doc/BRIEF.md
# Serial Calendar Clock Command and Shift Interface

This block sits behind a byte-wide command port and turns successive writes into the three control lines of a serial calendar clock: a strobe, a shift clock and a serial data-in bit. Software toggles those lines by writing bytes. A falling strobe between two writes commits a command. The command can choose a shift mode, copy a snapshot of the current date and time into a 48-bit shift register, or set the rate of a periodic interrupt pulse. A rising shift clock in serial mode moves the register right by one place. Before the move, the previous data-in bit is merged in near the top. The lowest register bit is returned on a status byte, so software can read the snapshot one bit at a time.

The date and time come in as parallel ports from a timekeeper elsewhere on the chip. The block does not keep time itself. It produces a one-cycle interrupt pulse at one of three rates, derived by dividing a system clock whose frequency is a parameter, or it keeps the pulse off.

Top module: `cal_serial_if`

## Requirements
- R1: After reset the status byte reads 0xF8, the pulse is off (no interrupt pulse), the shift mode is 0, the shift register is zero and the latched command byte is 0x10 (only the shift-clock bit set).
- R2: Command byte fields: bit 3 is the strobe, bit 4 the shift clock, bit 5 serial data-in, and bits 2:0 the command code. The code and data-in bit used by an action come from the byte latched by the previous write.
- R3: A command is carried out only when the previous write had strobe 1 and shift clock 0 and the new write has strobe 0. Any other write pair executes no command, and the status stays as it was.
- R4: A command with code bit 2 clear sets the shift mode to code bits 1:0. Shift mode 3 copies the date and time snapshot into the shift register in the same write.
- R5: Snapshot layout: year (two-digit BCD) in [47:40], month (binary, 0 = first month) in [39:36], weekday (binary) in [35:32], day of month BCD in [31:24], hours BCD in [23:16], minutes BCD in [15:8], seconds BCD in [7:0].
- R6: When the shift clock goes 0 to 1 between two writes and the shift mode is 1, the previous data-in bit is ORed into bit 40 and the register then shifts right by one. In any other shift mode a clock rise leaves the register unchanged.
- R7: The status byte equals 0xF8 ORed with shift-register bit 0. It is valid in the cycle after the write.
- R8: Pulse modes 0, 1 and 2 give one interrupt every CLK_HZ/64, CLK_HZ/256 and CLK_HZ/2048 cycles. Each pulse is high for exactly one cycle.
- R9: A command with code bit 2 set loads the pulse mode from code bits 1:0. Moving from off to an enabled mode restarts the divider, so the first pulse comes exactly one period after the write.
- R10: Pulse mode 3 is off. No pulse appears from the cycle after that write onward.
- R11: Changing between two enabled pulse modes does not restart the divider. The next pulse arrives after the new period, counted from the previous pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | One-cycle write strobe for the command port |
| cmd_byte | input | 8 | Command byte carrying strobe, shift clock, data-in and code |
| sec_bcd | input | 8 | Current seconds, BCD |
| min_bcd | input | 8 | Current minutes, BCD |
| hour_bcd | input | 8 | Current hours, BCD |
| mday_bcd | input | 8 | Current day of month, BCD |
| wday_bin | input | 4 | Current weekday, binary |
| month_bin | input | 4 | Current month, binary, 0 = first month |
| year_bcd | input | 8 | Current two-digit year, BCD |
| status | output | 8 | 0xF8 ORed with shift-register bit 0 |
| tick_irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
The status byte is due one clock edge after the write that changes the register. The bench drives each write on a falling edge, holds it for one cycle and reads the status at the next falling edge, just after the capturing edge. The interrupt is registered. After an off-to-on write, the pulse appears a full divider period of edges after that write's edge. The bench counts falling edges from the write's return to the first high sample and compares that count with the period. For a rate change, it subtracts the two write cycles that elapsed since the previous pulse.

// File: rtl/cal_pkg.sv
package cal_pkg;

   // command byte bit positions (decoded by the command unit)
   localparam int CB_RATE_SEL = 2;
   localparam int CB_STROBE   = 3;
   localparam int CB_SCLK     = 4;
   localparam int CB_DIN      = 5;
   localparam int CMD_W       = 8;

   localparam int SNAP_W      = 48;
   localparam int INS_POS     = 40;

   localparam logic [1:0] RATE_OFF   = 2'd3;
   localparam logic [1:0] SHIFT_SER  = 2'd1;
   localparam logic [1:0] SHIFT_LOAD = 2'd3;

   typedef struct packed {
      logic [7:0] year;
      logic [3:0] month;
      logic [3:0] wday;
      logic [7:0] mday;
      logic [7:0] hour;
      logic [7:0] minute;
      logic [7:0] second;
   } snap_t;

   typedef struct packed {
      logic       shift_sel_wr;
      logic       rate_wr;
      logic [1:0] code;
      logic       clk_rise;
      logic       din;
   } cmd_evt_t;

endpackage

// File: rtl/cal_cmd_decode.sv
module cal_cmd_decode
   import cal_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CMD_W-1:0] wr_byte,
   output cmd_evt_t         evt
);

   localparam logic [CMD_W-1:0] CMD_RESET = CMD_W'(1) << CB_SCLK;

   logic [CMD_W-1:0] cmd_q;
   logic             strobe_fall;

   assign strobe_fall = wr_en && cmd_q[CB_STROBE] && !wr_byte[CB_STROBE]
                        && !cmd_q[CB_SCLK];

   always_comb begin
      evt.rate_wr      = strobe_fall && cmd_q[CB_RATE_SEL];
      evt.shift_sel_wr = strobe_fall && !cmd_q[CB_RATE_SEL];
      evt.code         = cmd_q[1:0];
      evt.clk_rise     = wr_en && !cmd_q[CB_SCLK] && wr_byte[CB_SCLK];
      evt.din          = cmd_q[CB_DIN];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     cmd_q <= CMD_RESET;
      else if (wr_en) cmd_q <= wr_byte;
   end

   AST_CMD_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cmd_q == $past(wr_byte))); // R2
   AST_CMD_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cmd_q)); // R3
   AST_NO_EVT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> !(evt.rate_wr || evt.shift_sel_wr || evt.clk_rise)); // R3

endmodule

// File: rtl/cal_shift_unit.sv
module cal_shift_unit
   import cal_pkg::*;
#(
   parameter int WIDTH = SNAP_W,
   parameter int INS   = INS_POS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cmd_evt_t         evt,
   input  logic [WIDTH-1:0] snap,
   output logic             lsb
);

   if (INS >= WIDTH || INS < 1) begin : g_bad_ins
      $error("insert position must lie inside the shift register");
   end

   logic [WIDTH-1:0] sreg_q;
   logic [1:0]       mode_q;
   logic [1:0]       eff_mode;
   logic             do_load;
   logic             do_shift;
   logic [WIDTH-1:0] ins_mask;

   assign eff_mode = evt.shift_sel_wr ? evt.code : mode_q;
   assign do_load  = evt.shift_sel_wr && (evt.code == SHIFT_LOAD);
   assign do_shift = evt.clk_rise && (eff_mode == SHIFT_SER);
   assign ins_mask = WIDTH'(evt.din) << INS;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 2'd0;
         sreg_q <= '0;
      end else begin
         if (evt.shift_sel_wr) mode_q <= evt.code;
         if (do_load)          sreg_q <= snap;
         else if (do_shift)    sreg_q <= (sreg_q | ins_mask) >> 1;
      end
   end

   assign lsb = sreg_q[0];

   AST_LOAD_TAKES_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
      do_load |=> (sreg_q == $past(snap))); // R4
   AST_SREG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt.shift_sel_wr || evt.clk_rise) |=> $stable(sreg_q)); // R6
   AST_TOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (do_shift && !do_load) |=> !sreg_q[WIDTH-1]); // R6
   AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !evt.shift_sel_wr |=> $stable(mode_q)); // R4

endmodule

// File: rtl/cal_rate_pulse.sv
module cal_rate_pulse
   import cal_pkg::*;
#(
   parameter int CLK_HZ    = 33554432,
   parameter int RATE_SLOW = 64,
   parameter int RATE_MID  = 256,
   parameter int RATE_FAST = 2048
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rate_wr,
   input  logic [1:0] rate_code,
   output logic       irq
);

   localparam int DIV_SLOW = CLK_HZ / RATE_SLOW;
   localparam int DIV_MID  = CLK_HZ / RATE_MID;
   localparam int DIV_FAST = CLK_HZ / RATE_FAST;
   localparam int N_RATES  = 3;
   localparam int CNT_W    = $clog2(DIV_SLOW + 1);

   function automatic int div_of(input int idx);
      case (idx)
         0:       return DIV_SLOW;
         1:       return DIV_MID;
         default: return DIV_FAST;
      endcase
   endfunction

   if (!(DIV_SLOW >= DIV_MID && DIV_MID >= DIV_FAST)) begin : g_bad_order
      $error("rates must rise from slow to fast");
   end

   logic [CNT_W-1:0]   cnt_q;
   logic [1:0]         mode_q;
   logic [N_RATES-1:0] hit;
   logic               mode_off;
   logic               tc;
   logic               clear;

   for (genvar gi = 0; gi < N_RATES; gi++) begin : g_rate
      localparam int D = div_of(gi);
      if (D < 2) begin : g_bad_div
         $error("each period must span at least two clock cycles");
      end
      assign hit[gi] = (cnt_q >= CNT_W'(D - 1));
   end

   assign mode_off = (mode_q == RATE_OFF);

   always_comb begin
      case (mode_q)
         2'd0:    tc = hit[0];
         2'd1:    tc = hit[1];
         2'd2:    tc = hit[2];
         default: tc = 1'b0;
      endcase
   end

   assign clear = mode_off || (rate_wr && (rate_code == RATE_OFF));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= RATE_OFF;
         cnt_q  <= '0;
         irq    <= 1'b0;
      end else begin
         if (rate_wr) mode_q <= rate_code;
         if (clear) begin
            cnt_q <= '0;
            irq   <= 1'b0;
         end else if (tc) begin
            cnt_q <= '0;
            irq   <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            irq   <= 1'b0;
         end
      end
   end

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R8
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      mode_off |-> !irq); // R10
   AST_ENABLE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_wr && mode_off && rate_code != RATE_OFF) |=> (cnt_q == '0 && !irq)); // R9

endmodule

// File: rtl/cal_serial_if.sv
module cal_serial_if
   import cal_pkg::*;
#(
   parameter int         CLK_HZ      = 33554432,
   parameter int         RATE_SLOW   = 64,
   parameter int         RATE_MID    = 256,
   parameter int         RATE_FAST   = 2048,
   parameter logic [7:0] STATUS_FILL = 8'hF8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_wr,
   input  logic [7:0] cmd_byte,
   input  logic [7:0] sec_bcd,
   input  logic [7:0] min_bcd,
   input  logic [7:0] hour_bcd,
   input  logic [7:0] mday_bcd,
   input  logic [3:0] wday_bin,
   input  logic [3:0] month_bin,
   input  logic [7:0] year_bcd,
   output logic [7:0] status,
   output logic       tick_irq
);

   if (STATUS_FILL[0]) begin : g_bad_fill
      $error("status fill must leave bit 0 free for the data-out bit");
   end

   cmd_evt_t evt;
   snap_t    snap;
   logic     dout;

   always_comb begin
      snap.year   = year_bcd;
      snap.month  = month_bin;
      snap.wday   = wday_bin;
      snap.mday   = mday_bcd;
      snap.hour   = hour_bcd;
      snap.minute = min_bcd;
      snap.second = sec_bcd;
   end

   cal_cmd_decode u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cmd_wr),
      .wr_byte (cmd_byte),
      .evt     (evt)
   );

   cal_shift_unit #(.WIDTH(SNAP_W), .INS(INS_POS)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt),
      .snap  (snap),
      .lsb   (dout)
   );

   cal_rate_pulse #(
      .CLK_HZ    (CLK_HZ),
      .RATE_SLOW (RATE_SLOW),
      .RATE_MID  (RATE_MID),
      .RATE_FAST (RATE_FAST)
   ) u_rate (
      .clk       (clk),
      .rst_n     (rst_n),
      .rate_wr   (evt.rate_wr),
      .rate_code (evt.code),
      .irq       (tick_irq)
   );

   assign status = STATUS_FILL | {7'd0, dout};

   AST_STATUS_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_wr |=> $stable(status)); // R7

endmodule

// File: tb/sim_cal_serial_if.sv
module sim_cal_serial_if;

   localparam int CLK_HZ   = 131072;
   localparam int DIV_SLOW = CLK_HZ / 64;
   localparam int DIV_MID  = CLK_HZ / 256;
   localparam int DIV_FAST = CLK_HZ / 2048;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [7:0] cmd_byte = 8'h00;
   logic [7:0] sec_bcd = 8'h00, min_bcd = 8'h00, hour_bcd = 8'h00, mday_bcd = 8'h01;
   logic [3:0] wday_bin = 4'd0, month_bin = 4'd0;
   logic [7:0] year_bcd = 8'h00;
   logic [7:0] status;
   logic       tick_irq;

   int errs = 0;
   int nchk = 0;
   bit done = 1'b0;

   logic [7:0]  m_cmd;
   logic [1:0]  m_smode;
   logic [47:0] m_sreg;

   always #2 clk = ~clk;

   cal_serial_if #(.CLK_HZ(CLK_HZ)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
      .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hour_bcd(hour_bcd),
      .mday_bcd(mday_bcd), .wday_bin(wday_bin), .month_bin(month_bin),
      .year_bcd(year_bcd), .status(status), .tick_irq(tick_irq)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] to_bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic logic [47:0] snap_now();
      return {year_bcd, month_bin, wday_bin, mday_bcd, hour_bcd, min_bcd, sec_bcd};
   endfunction

   // bench model written from R2..R6
   task automatic model_wr(input logic [7:0] b);
      if (m_cmd[3] && !b[3] && !m_cmd[4] && !m_cmd[2]) begin
         m_smode = m_cmd[1:0];
         if (m_smode == 2'd3) m_sreg = snap_now();
      end
      if (!m_cmd[4] && b[4] && m_smode == 2'd1)
         m_sreg = (m_sreg | (48'(m_cmd[5]) << 40)) >> 1;
      m_cmd = b;
   endtask

   task automatic wr(input logic [7:0] b);
      cmd_wr   = 1'b1;
      cmd_byte = b;
      @(negedge clk);
      cmd_wr   = 1'b0;
      model_wr(b);
   endtask

   task automatic issue(input logic [2:0] code);
      wr({5'b00001, code});
      wr(8'h00);
   endtask

   task automatic shift_once(input bit din);
      wr({2'b00, din, 5'b00000});
      wr({2'b00, din, 5'b10000});
      wr(8'h00);
   endtask

   task automatic wait_irq(output int n, input int lim);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!tick_irq && n < lim);
   endtask

   task automatic rand_date();
      sec_bcd   = to_bcd(int'($urandom_range(59)));
      min_bcd   = to_bcd(int'($urandom_range(59)));
      hour_bcd  = to_bcd(int'($urandom_range(23)));
      mday_bcd  = to_bcd(int'($urandom_range(31, 1)));
      wday_bin  = 4'($urandom_range(6));
      month_bin = 4'($urandom_range(11));
      year_bcd  = to_bcd(int'($urandom_range(99)));
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         errs++;
         nchk++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("Result: errors=%0d of %0d checks", errs, nchk);
         $finish;
      end
   end

   initial begin
      int n;
      int seen;
      logic [47:0] exp_v;
      void'($urandom(32'd1234));
      m_cmd = 8'h10; m_smode = 2'd0; m_sreg = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(status == 8'hF8, "R1 status after reset", status, 8'hF8);
      seen = 0;
      repeat (DIV_SLOW + 10) begin
         @(negedge clk);
         if (tick_irq) seen++;
      end
      chk(seen == 0, "R1 pulse off after reset", seen, 0);

      // R3: strobe fall with clock high, and strobe held high, do nothing
      sec_bcd = 8'h01;
      wr(8'h1B); wr(8'h10);
      chk(status == 8'hF8, "R3 clock high blocks command", status, 8'hF8);
      wr(8'h0B); wr(8'h0B);
      chk(status == 8'hF8, "R3 no strobe fall no command", status, 8'hF8);
      wr(8'h00);
      chk(status == 8'hF9, "R4 load on valid strobe fall", status, 8'hF9);

      // R5 snapshot layout, read out serially (R6 shift)
      sec_bcd = 8'h59; min_bcd = 8'h37; hour_bcd = 8'h23; mday_bcd = 8'h31;
      wday_bin = 4'd6; month_bin = 4'd11; year_bcd = 8'h99;
      exp_v = {8'h99, 4'd11, 4'd6, 8'h31, 8'h23, 8'h37, 8'h59};
      issue(3'd3);
      issue(3'd1);
      for (int i = 0; i < 48; i++) begin
         chk(status[0] == exp_v[i], "R5 snapshot bit", {56'd0, status}, {63'd0, exp_v[i]});
         shift_once(1'b0);
      end
      chk(status == 8'hF8, "R6 register empty after 48 shifts", status, 8'hF8);

      // R6 data-in merge at bit 40 then shift -> reaches bit 0 after 40 shifts
      shift_once(1'b1);
      for (int i = 0; i < 38; i++) shift_once(1'b0);
      chk(status == 8'hF8, "R6 merged bit not yet at bit 0", status, 8'hF8);
      shift_once(1'b0);
      chk(status == 8'hF9, "R6 merged bit arrives at bit 0", status, 8'hF9);

      // R6 clock rise outside serial mode has no effect
      issue(3'd3);
      issue(3'd0);
      wr(8'h00); wr(8'h10); wr(8'h00);
      chk(status == 8'hF9, "R6 no shift in mode 0", status, 8'hF9);

      // R7 random raw writes checked against the bench model
      for (int i = 0; i < 600; i++) begin
         if (i % 16 == 0) rand_date();
         wr(8'($urandom));
         chk(status == (8'hF8 | {7'd0, m_sreg[0]}), "R7 status vs model",
             status, 8'hF8 | {7'd0, m_sreg[0]});
      end
      issue(3'd7);
      @(negedge clk);
      chk(!tick_irq, "R10 off after random phase", tick_irq, 0);

      // R9 off to fast: first pulse one period after the write
      issue(3'd6);
      wait_irq(n, DIV_SLOW * 2);
      chk(n == DIV_FAST, "R9 first fast pulse delay", n, DIV_FAST);
      wait_irq(n, DIV_SLOW * 2);
      chk(n == DIV_FAST, "R8 fast period", n, DIV_FAST);
      @(negedge clk);
      chk(!tick_irq, "R8 pulse lasts one cycle", tick_irq, 0);
      wait_irq(n, DIV_SLOW * 2);
      chk(n == DIV_FAST - 1, "R8 fast period after width check", n, DIV_FAST - 1);

      // R11 switch fast -> mid right at a pulse: divider keeps running
      issue(3'd5);
      wait_irq(n, DIV_SLOW * 2);
      chk(n == DIV_MID - 2, "R11 no restart on rate change", n, DIV_MID - 2);
      wait_irq(n, DIV_SLOW * 2);
      chk(n == DIV_MID, "R8 mid period", n, DIV_MID);

      // R10 off stops pulses
      issue(3'd7);
      chk(!tick_irq, "R10 no pulse after off write", tick_irq, 0);
      seen = 0;
      repeat (3000) begin
         @(negedge clk);
         if (tick_irq) seen++;
      end
      chk(seen == 0, "R10 silent while off", seen, 0);

      // R9 / R8 slow rate from off
      issue(3'd4);
      wait_irq(n, DIV_SLOW * 2);
      chk(n == DIV_SLOW, "R9 first slow pulse delay", n, DIV_SLOW);
      wait_irq(n, DIV_SLOW * 2);
      chk(n == DIV_SLOW, "R8 slow period", n, DIV_SLOW);
      issue(3'd7);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
   end

endmodule